// File: doc/BRIEF.md
# Key-Locked Watchdog Reset Timer

This block is a watchdog timer reached through a small 16-bit register port. A 32-bit timeout is written as two 16-bit halves. A control register starts and stops the count and decides what happens at expiry. The count steps down once per strobe of a 32.768 kHz tick enable, so a load of 1 or 2 gives a timeout of a few tens of microseconds, and a load of 1638 gives about 50 ms.

A key register guards all configuration. The load halves and the control register accept writes only while the block is unlocked. The key register itself always accepts writes. Reads are never blocked.

At expiry the block does one of two things. If reset is enabled, it drives a system reset pulse of fixed length. If reset is not enabled, it sets a sticky expired flag. In both cases it stops counting.

Top module: `wdt_keylock`

## Requirements
- R1: After reset the block is locked. Both load halves and all control bits read as zero, and `sys_rst_o` is low.
- R2: The key register is at offset 0xA0. Writing 0xE551 to it unlocks the block. Writing any other value locks it. A read of the key register returns the unlock state in bit 0 (1 = unlocked).
- R3: While the block is locked, writes to the load halves (0x80, 0x84) and to the control register (0x88) are ignored. The old values still read back, and the count does not start.
- R4: The low half is at 0x80 and the high half at 0x84. Each reads back as written. When the run bit (control bit 1) is written to 1 while run is clear, the counter is loaded with {high, low}.
- R5: While run is set, each tick strobe lowers the counter by one. Expiry happens on tick number max(N,1), where N is the loaded value. Clock cycles without a tick do not advance the count.
- R6: If the reset-enable bit (control bit 3) is set at expiry, `sys_rst_o` is high for exactly 4 clock cycles, starting on the cycle after the expiring tick, and run is cleared.
- R7: If reset-enable is clear at expiry, run is cleared, the expired flag (control bit 0) is set, and no reset pulse appears. Writing 1 to bit 0 clears the flag. Writing 0 to bit 0 leaves it unchanged.
- R8: If an expiry and a control write land in the same cycle, the expiry decides the run bit and the expired flag. The flag stays set even if the write tries to clear it. The other control bits take the written values.
- R9: Writing run = 0 pauses the count, and ticks then have no effect. Writing run = 1 again reloads the full load value. The mode bit (control bit 2) is stored and read back without affecting the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | 32.768 kHz count enable, one clock wide |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data for `addr_i`, combinational |
| sys_rst_o | output | 1 | System reset pulse |

## Verification
Two events can land in the same clock edge: the expiring tick and a software write to the control register. The bench provokes this by raising `tick_i` in the same cycle as a control write that both tries to clear the expired flag and keeps run set. It then reads control back and expects expired = 1 and run = 0, because expiry takes precedence. A later plain clear write must then drop the flag. Random load values, reset-enable choices and idle gaps between ticks are checked against a bench model of the tick on which expiry falls.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    // Control register field positions (software decodes these)
    localparam int CTRL_EXPIRED = 0;
    localparam int CTRL_RUN     = 1;
    localparam int CTRL_MODE    = 2;
    localparam int CTRL_RSTEN   = 3;

    typedef struct packed {
        logic rsten;
        logic mode;
        logic run;
        logic expired;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_lockreg.sv
module wdt_lockreg #(
    parameter int             RW  = 16,
    parameter logic [RW-1:0]  KEY = 16'hE551
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_i,
    input  logic          sel_i,
    input  logic [RW-1:0] wdata_i,
    output logic          unlocked_o
);
    logic open_d, open_q;

    always_comb begin
        open_d = open_q;
        if (wr_i && sel_i) open_d = (wdata_i == KEY);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) open_q <= 1'b0;
        else         open_q <= open_d;
    end

    assign unlocked_o = open_q;
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int CW = 32
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          load_i,
    input  logic [CW-1:0] load_val_i,
    input  logic          run_i,
    input  logic          tick_i,
    output logic          expire_o,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_d, cnt_q;
    logic          step;

    assign step     = run_i && tick_i && !load_i;
    assign expire_o = step && (cnt_q <= CW'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)                      cnt_d = load_val_i;
        else if (step && cnt_q != '0)    cnt_d = cnt_q - CW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/wdt_pulse.sv
module wdt_pulse #(
    parameter int PULSE_LEN = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic trig_i,
    output logic pulse_o
);
    localparam int PW = $clog2(PULSE_LEN + 1);

    logic [PW-1:0] left_d, left_q;

    always_comb begin
        left_d = left_q;
        if (trig_i)             left_d = PW'(PULSE_LEN);
        else if (left_q != '0)  left_d = left_q - PW'(1);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) left_q <= '0;
        else         left_q <= left_d;
    end

    assign pulse_o = (left_q != '0);
endmodule

// File: rtl/wdt_keylock.sv
module wdt_keylock #(
    parameter int            RW        = 16,
    parameter int            AW        = 8,
    parameter logic [RW-1:0] KEY       = 16'hE551,
    parameter int            PULSE_LEN = 4,
    parameter logic [AW-1:0] ADDR_LO   = 8'h80,
    parameter logic [AW-1:0] ADDR_HI   = 8'h84,
    parameter logic [AW-1:0] ADDR_CTRL = 8'h88,
    parameter logic [AW-1:0] ADDR_LOCK = 8'hA0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          tick_i,
    input  logic          wr_i,
    input  logic [AW-1:0] addr_i,
    input  logic [RW-1:0] wdata_i,
    output logic [RW-1:0] rdata_o,
    output logic          sys_rst_o
);
    import wdt_pkg::*;

    localparam int CW = 2 * RW;

    typedef struct packed {
        logic [RW-1:0] lo;
        logic [RW-1:0] hi;
        wdt_ctrl_t     ctrl;
    } regs_t;

    regs_t         r_d, r_q;
    logic          unlocked;
    logic          wr_cfg;
    logic          start;
    logic          expire;
    logic [CW-1:0] cnt;

    wdt_lockreg #(.RW(RW), .KEY(KEY)) u_lock (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (wr_i),
        .sel_i      (addr_i == ADDR_LOCK),
        .wdata_i    (wdata_i),
        .unlocked_o (unlocked)
    );

    assign wr_cfg = wr_i && unlocked;
    assign start  = wr_cfg && (addr_i == ADDR_CTRL) && wdata_i[CTRL_RUN] && !r_q.ctrl.run;

    wdt_countdown #(.CW(CW)) u_cnt (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .load_i     (start),
        .load_val_i ({r_q.hi, r_q.lo}),
        .run_i      (r_q.ctrl.run),
        .tick_i     (tick_i),
        .expire_o   (expire),
        .cnt_o      (cnt)
    );

    wdt_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .trig_i  (expire && r_q.ctrl.rsten),
        .pulse_o (sys_rst_o)
    );

    always_comb begin
        r_d = r_q;
        if (wr_cfg) begin
            if (addr_i == ADDR_LO) r_d.lo = wdata_i;
            if (addr_i == ADDR_HI) r_d.hi = wdata_i;
            if (addr_i == ADDR_CTRL) begin
                r_d.ctrl.run   = wdata_i[CTRL_RUN];
                r_d.ctrl.mode  = wdata_i[CTRL_MODE];
                r_d.ctrl.rsten = wdata_i[CTRL_RSTEN];
                if (wdata_i[CTRL_EXPIRED]) r_d.ctrl.expired = 1'b0;
            end
        end
        // expiry outranks a same-cycle control write
        if (expire) begin
            r_d.ctrl.run = 1'b0;
            if (!r_q.ctrl.rsten) r_d.ctrl.expired = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_LO)   rdata_o = r_q.lo;
        if (addr_i == ADDR_HI)   rdata_o = r_q.hi;
        if (addr_i == ADDR_CTRL) rdata_o = RW'(r_q.ctrl);
        if (addr_i == ADDR_LOCK) rdata_o = RW'(unlocked);
    end
endmodule

// File: rtl/wdt_keylock_chk.sv
module wdt_keylock_chk #(
    parameter int            RW        = 16,
    parameter int            AW        = 8,
    parameter int            PULSE_LEN = 4,
    parameter logic [AW-1:0] ADDR_LO   = 8'h80,
    parameter logic [AW-1:0] ADDR_CTRL = 8'h88
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic            wr_i,
    input logic [AW-1:0]   addr_i,
    input logic [RW-1:0]   wdata_i,
    input logic            unlocked,
    input logic [RW-1:0]   lo_q,
    input logic            run_q,
    input logic            rsten_q,
    input logic            expired_q,
    input logic [2*RW-1:0] cnt,
    input logic            sys_rst_o
);
    logic [7:0] hi_len_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)        hi_len_q <= '0;
        else if (sys_rst_o) hi_len_q <= hi_len_q + 8'd1;
        else                hi_len_q <= '0;
    end

    p_locked_ignore_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && !unlocked && addr_i == ADDR_LO) |=> $stable(lo_q));

    p_count_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        run_q |=> (cnt <= $past(cnt)));

    p_pulse_bound_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sys_rst_o |-> (hi_len_q < 8'(PULSE_LEN)));

    p_pulse_len_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sys_rst_o) |-> (hi_len_q == 8'(PULSE_LEN)));

    p_pulse_stops_run_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sys_rst_o) |-> (!run_q && $past(rsten_q)));

    p_expired_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expired_q && !(wr_i && unlocked && addr_i == ADDR_CTRL && wdata_i[0])) |=> expired_q);
endmodule

bind wdt_keylock wdt_keylock_chk #(
    .RW(RW), .AW(AW), .PULSE_LEN(PULSE_LEN), .ADDR_LO(ADDR_LO), .ADDR_CTRL(ADDR_CTRL)
) u_chk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_i      (wr_i),
    .addr_i    (addr_i),
    .wdata_i   (wdata_i),
    .unlocked  (unlocked),
    .lo_q      (r_q.lo),
    .run_q     (r_q.ctrl.run),
    .rsten_q   (r_q.ctrl.rsten),
    .expired_q (r_q.ctrl.expired),
    .cnt       (cnt),
    .sys_rst_o (sys_rst_o)
);

// File: tb/wdt_keylock_test.sv
module wdt_keylock_test;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        tick_i = 1'b0;
    logic        wr_i = 1'b0;
    logic [7:0]  addr_i = 8'h00;
    logic [15:0] wdata_i = 16'h0000;
    logic [15:0] rdata_o;
    logic        sys_rst_o;

    int n_chk = 0;
    int n_bad = 0;

    localparam logic [7:0] A_LO = 8'h80, A_HI = 8'h84, A_CTRL = 8'h88, A_LOCK = 8'hA0;
    localparam logic [15:0] KEY = 16'hE551;

    wdt_keylock uut (
        .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .wr_i(wr_i),
        .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .sys_rst_o(sys_rst_o)
    );

    always #10 clk_i = ~clk_i;

    function automatic int ticks_to_expire(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [15:0] d);
        @(negedge clk_i);
        wr_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk_i);
        wr_i = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [15:0] d);
        addr_i = a;
        #1;
        d = rdata_o;
    endtask

    task automatic tick();
        @(negedge clk_i);
        tick_i = 1'b1;
        @(negedge clk_i);
        tick_i = 1'b0;
    endtask

    task automatic finish_up();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // one full run: load n, start with rsten, expect expiry on the modelled tick
    task automatic run_once(input int n, input bit rsten, input bit gaps);
        logic [15:0] v;
        int k;
        k = ticks_to_expire(n);
        wr(A_LO, 16'(n));
        wr(A_HI, 16'h0000);
        wr(A_CTRL, {12'h0, rsten, 1'b0, 1'b1, 1'b1});
        for (int i = 1; i < k; i++) begin
            if (gaps) repeat ($urandom_range(0, 3)) @(negedge clk_i);
            tick();
            check("R5 no early expiry", {31'b0, sys_rst_o}, 32'd0);
        end
        tick();
        for (int c = 0; c < 4; c++) begin
            check(rsten ? "R6 pulse high" : "R7 no pulse", {31'b0, sys_rst_o}, {31'b0, rsten});
            @(negedge clk_i);
        end
        check("R6 pulse ends", {31'b0, sys_rst_o}, 32'd0);
        rd(A_CTRL, v);
        check("R6/R7 run cleared, flag", {28'b0, v[3:0]}, {28'b0, rsten, 2'b00, !rsten});
    endtask

    initial begin
        repeat (100000) @(posedge clk_i);
        n_chk++; n_bad++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        finish_up();
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        @(negedge clk_i);

        // R1 reset state
        rd(A_LO, v);   check("R1 lo zero", {16'b0, v}, 32'd0);
        rd(A_HI, v);   check("R1 hi zero", {16'b0, v}, 32'd0);
        rd(A_CTRL, v); check("R1 ctrl zero", {16'b0, v}, 32'd0);
        rd(A_LOCK, v); check("R1 locked", {16'b0, v}, 32'd0);
        check("R1 rst low", {31'b0, sys_rst_o}, 32'd0);

        // R3 locked writes ignored
        wr(A_LO, 16'h1234);
        wr(A_CTRL, 16'h000A);
        rd(A_LO, v);   check("R3 lo held", {16'b0, v}, 32'd0);
        rd(A_CTRL, v); check("R3 ctrl held", {16'b0, v}, 32'd0);
        tick();
        check("R3 no pulse", {31'b0, sys_rst_o}, 32'd0);

        // R2 unlock/lock
        wr(A_LOCK, KEY);
        rd(A_LOCK, v); check("R2 unlocked", {16'b0, v}, 32'd1);
        wr(A_LOCK, ~KEY);
        rd(A_LOCK, v); check("R2 relocked", {16'b0, v}, 32'd0);
        wr(A_LOCK, KEY);

        // R4 readback
        wr(A_LO, 16'hBEEF); wr(A_HI, 16'h0001);
        rd(A_LO, v); check("R4 lo readback", {16'b0, v}, 32'h0000BEEF);
        rd(A_HI, v); check("R4 hi readback", {16'b0, v}, 32'h00000001);
        // R4 high half counts: {1,0} must survive many ticks
        wr(A_LO, 16'h0000);
        wr(A_CTRL, 16'h000A);
        for (int i = 0; i < 8; i++) tick();
        rd(A_CTRL, v); check("R4 hi half used, still running", {28'b0, v[3:0]}, 32'hA);
        check("R4 no pulse", {31'b0, sys_rst_o}, 32'd0);
        wr(A_CTRL, 16'h0000);

        // R9 mode bit readback and pause
        wr(A_CTRL, 16'h0004);
        rd(A_CTRL, v); check("R9 mode stored", {28'b0, v[3:0]}, 32'h4);
        wr(A_LO, 16'd3); wr(A_HI, 16'd0);
        wr(A_CTRL, 16'h000A);
        tick();
        wr(A_CTRL, 16'h0008);
        for (int i = 0; i < 5; i++) tick();
        check("R9 paused no pulse", {31'b0, sys_rst_o}, 32'd0);
        run_once(3, 1'b1, 1'b0);   // R9 restart reloads full value

        // R5 clock cycles without tick do not count
        wr(A_LO, 16'd1); wr(A_CTRL, 16'h000A);
        repeat (20) @(negedge clk_i);
        check("R5 idle cycles ignored", {31'b0, sys_rst_o}, 32'd0);
        wr(A_CTRL, 16'h0000);

        // R5 zero load expires on first tick
        run_once(0, 1'b1, 1'b0);

        // R7 flag clear semantics
        run_once(2, 1'b0, 1'b0);
        wr(A_CTRL, 16'h0000);
        rd(A_CTRL, v); check("R7 write 0 keeps flag", {31'b0, v[0]}, 32'd1);
        wr(A_CTRL, 16'h0001);
        rd(A_CTRL, v); check("R7 W1C clears", {31'b0, v[0]}, 32'd0);

        // R8 expiry and control write in the same cycle
        run_once(1, 1'b0, 1'b0);
        wr(A_LO, 16'd2); wr(A_CTRL, 16'h0003);
        tick();
        @(negedge clk_i);
        tick_i = 1'b1; wr_i = 1'b1; addr_i = A_CTRL; wdata_i = 16'h0007;
        @(negedge clk_i);
        tick_i = 1'b0; wr_i = 1'b0;
        rd(A_CTRL, v); check("R8 expiry wins", {28'b0, v[3:0]}, 32'h5);
        wr(A_CTRL, 16'h0001);
        rd(A_CTRL, v); check("R8 later clear", {31'b0, v[0]}, 32'd0);

        // random runs
        for (int it = 0; it < 20; it++) begin
            run_once(int'($urandom_range(0, 12)), 1'($urandom_range(0, 1)), 1'b1);
            wr(A_CTRL, 16'h0001);
        end

        finish_up();
    end
endmodule